// File: doc/BRIEF.md
# Hybrid Register/RAM Operand Stack

This block is a last-in-first-out stack of 48-bit operand words for a stack-oriented datapath. The three most accessible cells are flip-flop registers (called T1, T2 and T3 here, T1 being the top). Every deeper cell lives in a small RAM of 16 entries. The total capacity is 19 cells. Words in the RAM are never shifted. Instead, a write pointer and a read pointer select the RAM entry, and the read pointer always stays one entry behind the write pointer. A pop therefore reads the entry most recently written with no pointer correction.

A single command port drives the block. Commands cover:
- moving words to and from a memory-bus stub,
- single-length and double-length integer addition on the top cells,
- exchanging the top two cells,
- copying the top cell,
- pushing a zero word,
- discarding the top cell.

Every push-type command runs a fixed three-phase spill through two buffer registers. The block raises `busy` for the whole transfer. Every other command completes at the edge that accepts it.

Each cell carries a valid bit, so an empty cell is distinct from a cell holding the value zero. A command that needs more cells than are present is refused and reported. So is a push into a full stack.

Top module: `opstack_top`

## Requirements
- R1: After reset, `tos_valid`, `busy`, `overflow`, `underflow` and `mem_wr_valid` are all 0.
- R2: A command is accepted on a rising edge where `cmd_valid` is 1 and `busy` is 0. A push (push-from-bus code 1, duplicate code 6, push-zero code 7) sets `busy` for exactly three cycles. The new top word appears when `busy` falls. Commands presented while `busy` is 1 have no effect.
- R3: Words come back in last-in-first-out order at every depth from 1 to 19, including words that passed through the RAM.
- R4: A push while all 19 cells hold data is refused. It sets `overflow` to 1, does not raise `busy`, and leaves all 19 stored words unchanged.
- R5: A command is refused when it finds fewer valid cells than it needs. The needs are: 1 for pop (code 2), erase (code 8) and duplicate; 2 for add (code 3) and swap (code 5); 4 for double add (code 4). A refused command sets `underflow` to 1 and leaves the stack unchanged. Every accepted command (code 1 to 8) rewrites both flags, and the two are never 1 together.
- R6: Add (code 3) puts T1+T2 modulo 2^48 into T1 and moves the deeper cells up one place.
- R7: Double add (code 4) treats {T1,T2} as one 96-bit operand, with T1 as the more significant half, and the next two cells {T3,T4} as a second. It leaves the 96-bit sum in T1,T2, propagating the carry across the halves, and moves the deeper cells up two places.
- R8: Swap (code 5) exchanges T1 and T2.
- R9: Duplicate (code 6) pushes a copy of T1.
- R10: Push-zero (code 7) pushes a valid all-zero word. `tos_valid` is 1 and `tos_data` is 0 afterwards.
- R11: Erase (code 8) discards T1, moves the stack up one place, and produces no bus write.
- R12: Pop (code 2) moves the stack up one place. One cycle after acceptance it drives `mem_wr_valid` high for exactly one cycle, with the old T1 on `mem_wr_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 4 | Command code (0 = none, 1..8 as listed in the requirements) |
| mem_rd_data | input | 48 | Word supplied by the bus stub for push-from-bus, sampled at acceptance |
| busy | output | 1 | Multi-phase push in progress |
| tos_data | output | 48 | Content of T1 |
| tos_valid | output | 1 | T1 holds data |
| overflow | output | 1 | Last accepted command was a refused push into a full stack |
| underflow | output | 1 | Last accepted command lacked operands |
| mem_wr_valid | output | 1 | One-cycle strobe carrying a popped word |
| mem_wr_data | output | 48 | Popped word |

## Verification
Most faults in this block hide inside the RAM. A pointer that slips, or a spill written to the wrong entry, cannot be seen at the ports until the stack is drained past its third cell. At that point the fourth and later pops return a wrong word, a stale word or a word with its valid bit missing. For that reason the tests fill to full depth and drain completely.

A valid bit that is lost or wrongly set shows as a spurious `underflow` or `overflow`, or as a missing one, on the next command that tests depth. A fault in a phase of the push shows as a `busy` pulse of the wrong length, or as a wrong T2 or T3 on the following pops.

// File: rtl/opstack_pkg.sv
package opstack_pkg;

   typedef enum logic [3:0] {
      OP_NONE  = 4'd0,
      OP_PUSH  = 4'd1,
      OP_POP   = 4'd2,
      OP_ADD   = 4'd3,
      OP_ADD2  = 4'd4,
      OP_SWAP  = 4'd5,
      OP_DUP   = 4'd6,
      OP_ZERO  = 4'd7,
      OP_ERASE = 4'd8
   } op_e;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_SNAP  = 2'd1,
      PH_SPILL = 2'd2,
      PH_LOAD  = 2'd3
   } phase_e;

endpackage

// File: rtl/opstack_ram.sv
module opstack_ram #(
   parameter int W     = 48,
   parameter int DEPTH = 16,
   parameter int AW    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [W-1:0]     wdata,
   input  logic             wvld,
   input  logic             clr_a_en,
   input  logic [AW-1:0]    clr_a,
   input  logic             clr_b_en,
   input  logic [AW-1:0]    clr_b,
   input  logic [AW-1:0]    raddr_a,
   input  logic [AW-1:0]    raddr_b,
   output logic [W-1:0]     rdata_a,
   output logic [W-1:0]     rdata_b,
   output logic [DEPTH-1:0] vld
);

   logic [W-1:0] mem [DEPTH];

   // data array: written only into an empty entry, never reset
   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata_a = mem[raddr_a];
   assign rdata_b = mem[raddr_b];

   // one occupancy flag per entry
   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic occ_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            occ_q <= 1'b0;
         end else if (we && (waddr == AW'(i))) begin
            occ_q <= wvld;
         end else if ((clr_a_en && (clr_a == AW'(i))) ||
                      (clr_b_en && (clr_b == AW'(i)))) begin
            occ_q <= 1'b0;
         end
      end
      assign vld[i] = occ_q;
   end

endmodule

// File: rtl/opstack_alu.sv
module opstack_alu #(
   parameter int W     = 48,
   parameter bit SPLIT = 1'b1
) (
   input  logic [W-1:0] t1,
   input  logic [W-1:0] t2,
   input  logic [W-1:0] t3,
   input  logic [W-1:0] t4,
   output logic [W-1:0] sum_s,
   output logic [W-1:0] sum_hi,
   output logic [W-1:0] sum_lo
);

   assign sum_s = t1 + t2;

   if (SPLIT) begin : g_split
      // low half first, carry rippled into the high half
      logic [W:0] lo_x;
      assign lo_x   = {1'b0, t2} + {1'b0, t4};
      assign sum_lo = lo_x[W-1:0];
      assign sum_hi = t1 + t3 + {{(W-1){1'b0}}, lo_x[W]};
   end else begin : g_wide
      logic [2*W-1:0] full_x;
      assign full_x = {t1, t2} + {t3, t4};
      assign sum_hi = full_x[2*W-1:W];
      assign sum_lo = full_x[W-1:0];
   end

endmodule

// File: rtl/opstack_ctrl.sv
module opstack_ctrl
   import opstack_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [3:0] cmd_op,
   input  logic       have1,
   input  logic       have2,
   input  logic       have4,
   input  logic       full,
   output logic       busy,
   output logic       go_push,
   output logic       go_up1,
   output logic       go_up2,
   output logic       go_swap,
   output logic       go_pop,
   output logic       sel_add,
   output logic       ph_snap,
   output logic       ph_spill,
   output logic       ph_load,
   output logic       flag_upd,
   output logic       ovf_err,
   output logic       udf_err
);

   phase_e     st_q;
   op_e        op;
   logic       legal, push_t, up1_t, up2_t, swap_t, short, go;
   logic [2:0] need;

   assign op = op_e'(cmd_op);

   always_comb begin
      legal  = 1'b1;
      push_t = 1'b0;
      up1_t  = 1'b0;
      up2_t  = 1'b0;
      swap_t = 1'b0;
      need   = 3'd0;
      case (op)
         OP_PUSH, OP_ZERO: push_t = 1'b1;
         OP_DUP:           begin push_t = 1'b1; need = 3'd1; end
         OP_POP, OP_ERASE: begin up1_t  = 1'b1; need = 3'd1; end
         OP_ADD:           begin up1_t  = 1'b1; need = 3'd2; end
         OP_SWAP:          begin swap_t = 1'b1; need = 3'd2; end
         OP_ADD2:          begin up2_t  = 1'b1; need = 3'd4; end
         default:          legal = 1'b0;
      endcase
   end

   assign short = ((need >= 3'd1) && !have1) ||
                  ((need >= 3'd2) && !have2) ||
                  ((need == 3'd4) && !have4);

   assign busy     = (st_q != PH_IDLE);
   assign flag_upd = cmd_valid && !busy && legal;
   assign udf_err  = short;
   assign ovf_err  = push_t && full && !short;
   assign go       = flag_upd && !udf_err && !ovf_err;

   assign go_push  = go && push_t;
   assign go_up1   = go && up1_t;
   assign go_up2   = go && up2_t;
   assign go_swap  = go && swap_t;
   assign go_pop   = go && (op == OP_POP);
   assign sel_add  = (op == OP_ADD);

   assign ph_snap  = (st_q == PH_SNAP);
   assign ph_spill = (st_q == PH_SPILL);
   assign ph_load  = (st_q == PH_LOAD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= PH_IDLE;
      end else begin
         case (st_q)
            PH_IDLE:  if (go_push) st_q <= PH_SNAP;
            PH_SNAP:  st_q <= PH_SPILL;
            PH_SPILL: st_q <= PH_LOAD;
            default:  st_q <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/opstack_top.sv
module opstack_top
   import opstack_pkg::*;
#(
   parameter int WORD_W        = 48,
   parameter int RAM_DEPTH     = 16,
   parameter bit SPLIT_DBL_ADD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [3:0]        cmd_op,
   input  logic [WORD_W-1:0] mem_rd_data,
   output logic              busy,
   output logic [WORD_W-1:0] tos_data,
   output logic              tos_valid,
   output logic              overflow,
   output logic              underflow,
   output logic              mem_wr_valid,
   output logic [WORD_W-1:0] mem_wr_data
);

   localparam int PTR_W = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1;

   if ((RAM_DEPTH < 2) || ((RAM_DEPTH & (RAM_DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("opstack_top: RAM_DEPTH must be a power of two, at least 2");
   end
   if (WORD_W < 2) begin : g_bad_width
      $error("opstack_top: WORD_W must be at least 2");
   end

   // register cells, spill buffers and staged word
   logic [WORD_W-1:0] t1_q, t2_q, t3_q, bf1_q, bf2_q, stage_q;
   logic              t1v_q, t2v_q, t3v_q, bf1v_q, bf2v_q;
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, rd_prev;
   logic [RAM_DEPTH-1:0] ram_vld;
   logic [WORD_W-1:0] ram_rd_a, ram_rd_b;
   logic              ram_we;
   logic [WORD_W-1:0] sum_s, sum_hi, sum_lo;
   logic              ovf_q, udf_q, wrv_q;
   logic [WORD_W-1:0] wrd_q;

   logic go_push, go_up1, go_up2, go_swap, go_pop, sel_add;
   logic ph_snap, ph_spill, ph_load, flag_upd, ovf_err, udf_err;
   logic have1, have2, have4, full;

   assign rd_prev = rd_ptr - PTR_W'(1);
   assign have1   = t1v_q;
   assign have2   = t1v_q && t2v_q;
   assign have4   = have2 && t3v_q && ram_vld[rd_ptr];
   assign full    = t3v_q && ram_vld[wr_ptr];
   assign ram_we  = ph_spill;

   opstack_ctrl i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .have1     (have1),
      .have2     (have2),
      .have4     (have4),
      .full      (full),
      .busy      (busy),
      .go_push   (go_push),
      .go_up1    (go_up1),
      .go_up2    (go_up2),
      .go_swap   (go_swap),
      .go_pop    (go_pop),
      .sel_add   (sel_add),
      .ph_snap   (ph_snap),
      .ph_spill  (ph_spill),
      .ph_load   (ph_load),
      .flag_upd  (flag_upd),
      .ovf_err   (ovf_err),
      .udf_err   (udf_err)
   );

   opstack_ram #(
      .W     (WORD_W),
      .DEPTH (RAM_DEPTH),
      .AW    (PTR_W)
   ) i_ram (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (ram_we),
      .waddr    (wr_ptr),
      .wdata    (t3_q),
      .wvld     (t3v_q),
      .clr_a_en (go_up1 || go_up2),
      .clr_a    (rd_ptr),
      .clr_b_en (go_up2),
      .clr_b    (rd_prev),
      .raddr_a  (rd_ptr),
      .raddr_b  (rd_prev),
      .rdata_a  (ram_rd_a),
      .rdata_b  (ram_rd_b),
      .vld      (ram_vld)
   );

   opstack_alu #(
      .W     (WORD_W),
      .SPLIT (SPLIT_DBL_ADD)
   ) i_alu (
      .t1     (t1_q),
      .t2     (t2_q),
      .t3     (t3_q),
      .t4     (ram_rd_a),
      .sum_s  (sum_s),
      .sum_hi (sum_hi),
      .sum_lo (sum_lo)
   );

   // staged word for a push, captured when the push is accepted
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
      end else if (go_push) begin
         case (op_e'(cmd_op))
            OP_DUP:  stage_q <= t1_q;
            OP_ZERO: stage_q <= '0;
            default: stage_q <= mem_rd_data;
         endcase
      end
   end

   // phase 1 snapshot into the spill buffers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bf1_q  <= '0;
         bf2_q  <= '0;
         bf1v_q <= 1'b0;
         bf2v_q <= 1'b0;
      end else if (ph_snap) begin
         bf1_q  <= t1_q;
         bf2_q  <= t2_q;
         bf1v_q <= t1v_q;
         bf2v_q <= t2v_q;
      end
   end

   // register cells
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t1_q  <= '0;
         t2_q  <= '0;
         t3_q  <= '0;
         t1v_q <= 1'b0;
         t2v_q <= 1'b0;
         t3v_q <= 1'b0;
      end else if (ph_load) begin
         t1_q  <= stage_q;
         t1v_q <= 1'b1;
         t2_q  <= bf1_q;
         t2v_q <= bf1v_q;
         t3_q  <= bf2_q;
         t3v_q <= bf2v_q;
      end else if (go_up1) begin
         t1_q  <= sel_add ? sum_s : t2_q;
         t1v_q <= sel_add ? 1'b1  : t2v_q;
         t2_q  <= t3_q;
         t2v_q <= t3v_q;
         t3_q  <= ram_rd_a;
         t3v_q <= ram_vld[rd_ptr];
      end else if (go_up2) begin
         t1_q  <= sum_hi;
         t1v_q <= 1'b1;
         t2_q  <= sum_lo;
         t2v_q <= 1'b1;
         t3_q  <= ram_rd_b;
         t3v_q <= ram_vld[rd_prev];
      end else if (go_swap) begin
         t1_q  <= t2_q;
         t2_q  <= t1_q;
      end
   end

   // RAM pointers, read pointer kept one entry behind the write pointer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= PTR_W'(RAM_DEPTH - 1);
      end else if (ph_load) begin
         wr_ptr <= wr_ptr + PTR_W'(1);
         rd_ptr <= rd_ptr + PTR_W'(1);
      end else if (go_up1) begin
         wr_ptr <= wr_ptr - PTR_W'(1);
         rd_ptr <= rd_ptr - PTR_W'(1);
      end else if (go_up2) begin
         wr_ptr <= wr_ptr - PTR_W'(2);
         rd_ptr <= rd_ptr - PTR_W'(2);
      end
   end

   // status flags and popped-word strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
         udf_q <= 1'b0;
         wrv_q <= 1'b0;
         wrd_q <= '0;
      end else begin
         if (flag_upd) begin
            ovf_q <= ovf_err;
            udf_q <= udf_err;
         end
         wrv_q <= go_pop;
         if (go_pop) wrd_q <= t1_q;
      end
   end

   assign tos_data     = t1_q;
   assign tos_valid    = t1v_q;
   assign overflow     = ovf_q;
   assign underflow    = udf_q;
   assign mem_wr_valid = wrv_q;
   assign mem_wr_data  = wrd_q;

endmodule

// File: rtl/opstack_chk.sv
module opstack_chk #(
   parameter int W     = 48,
   parameter int PTR_W = 4,
   parameter int DEPTH = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic [3:0]       cmd_op,
   input logic             busy,
   input logic [W-1:0]     tos_data,
   input logic             tos_valid,
   input logic             overflow,
   input logic             underflow,
   input logic             mem_wr_valid,
   input logic [PTR_W-1:0] wr_ptr,
   input logic [PTR_W-1:0] rd_ptr,
   input logic             ram_we,
   input logic [DEPTH-1:0] ram_vld
);

   AST_PUSH_THREE_PHASES: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ##1 busy ##1 busy ##1 !busy);                          // R2

   AST_BUSY_BLOCKS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !mem_wr_valid);                                               // R2

   AST_PTR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ptr == PTR_W'(wr_ptr - PTR_W'(1)));                                 // R3

   AST_RAM_WRITE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> !ram_vld[wr_ptr]);                                          // R3

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overflow) |-> (!busy && $stable(tos_data) && $stable(tos_valid))); // R4

   AST_UNDERFLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(underflow) |-> ($stable(tos_data) && $stable(tos_valid) && !mem_wr_valid)); // R5

   AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(overflow && underflow));                                             // R5

   AST_POP_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid |-> $past(cmd_valid && !busy && (cmd_op == 4'd2)));       // R12

endmodule

bind opstack_top opstack_chk #(
   .W     (WORD_W),
   .PTR_W (PTR_W),
   .DEPTH (RAM_DEPTH)
) i_opstack_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_valid    (cmd_valid),
   .cmd_op       (cmd_op),
   .busy         (busy),
   .tos_data     (tos_data),
   .tos_valid    (tos_valid),
   .overflow     (overflow),
   .underflow    (underflow),
   .mem_wr_valid (mem_wr_valid),
   .wr_ptr       (wr_ptr),
   .rd_ptr       (rd_ptr),
   .ram_we       (ram_we),
   .ram_vld      (ram_vld)
);

// File: tb/test_opstack_top.sv
module test_opstack_top;

   localparam int W = 48;
   localparam logic [3:0] C_PUSH = 4'd1, C_POP = 4'd2, C_ADD = 4'd3, C_ADD2 = 4'd4,
                          C_SWAP = 4'd5, C_DUP = 4'd6, C_ZERO = 4'd7, C_ERASE = 4'd8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [3:0]    cmd_op = 4'd0;
   logic [W-1:0]  mem_rd_data = '0;
   logic          busy, tos_valid, overflow, underflow, mem_wr_valid;
   logic [W-1:0]  tos_data, mem_wr_data;

   int   n_chk = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;
   logic          got_wv;
   logic [W-1:0]  got_wd;

   always #10 clk = ~clk;

   opstack_top i_opstack_top (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_valid    (cmd_valid),
      .cmd_op       (cmd_op),
      .mem_rd_data  (mem_rd_data),
      .busy         (busy),
      .tos_data     (tos_data),
      .tos_valid    (tos_valid),
      .overflow     (overflow),
      .underflow    (underflow),
      .mem_wr_valid (mem_wr_valid),
      .mem_wr_data  (mem_wr_data)
   );

   task automatic chk_w(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic chk_b(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   // present one command for one edge, then wait out any push
   task automatic do_op(input logic [3:0] op, input logic [W-1:0] d);
      @(negedge clk);
      cmd_valid   = 1'b1;
      cmd_op      = op;
      mem_rd_data = d;
      @(negedge clk);
      cmd_valid = 1'b0;
      got_wv    = mem_wr_valid;
      got_wd    = mem_wr_data;
      while (busy) @(negedge clk);
   endtask

   task automatic expect_pop(input string tag, input logic [W-1:0] exp);
      do_op(C_POP, '0);
      chk_b({tag, " strobe"}, got_wv, 1'b1);
      chk_w({tag, " word"}, got_wd, exp);
   endtask

   task automatic t_reset;
      chk_b("R1 tos_valid", tos_valid, 1'b0);
      chk_b("R1 busy", busy, 1'b0);
      chk_b("R1 overflow", overflow, 1'b0);
      chk_b("R1 underflow", underflow, 1'b0);
      chk_b("R1 mem_wr_valid", mem_wr_valid, 1'b0);
   endtask

   task automatic t_push_timing;
      logic [W-1:0] x;
      x = 48'hA5A5_0000_1234;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = C_PUSH; mem_rd_data = x;
      @(negedge clk);
      cmd_op = C_ZERO;                      // offered while busy: must be ignored
      chk_b("R2 busy phase 1", busy, 1'b1);
      @(negedge clk);
      chk_b("R2 busy phase 2", busy, 1'b1);
      @(negedge clk);
      chk_b("R2 busy phase 3", busy, 1'b1);
      cmd_valid = 1'b0;
      @(negedge clk);
      chk_b("R2 busy released", busy, 1'b0);
      chk_w("R2 new top", tos_data, x);
      chk_b("R2 top valid", tos_valid, 1'b1);
      expect_pop("R12 pop after push", x);
      @(negedge clk);
      chk_b("R12 strobe one cycle", mem_wr_valid, 1'b0);
      chk_b("R2 zero ignored while busy", tos_valid, 1'b0);
   endtask

   task automatic t_fill;
      for (int i = 0; i < 19; i++) do_op(C_PUSH, 48'h5000_0000_0000 + W'(i * 16'h0101));
      chk_w("R3 top after 19", tos_data, 48'h5000_0000_0000 + W'(18 * 16'h0101));
      chk_b("R4 no overflow at 19", overflow, 1'b0);
      do_op(C_PUSH, 48'hDEAD_DEAD_DEAD);
      chk_b("R4 overflow on 20th", overflow, 1'b1);
      chk_w("R4 top kept", tos_data, 48'h5000_0000_0000 + W'(18 * 16'h0101));
      for (int i = 18; i >= 0; i--) begin
         expect_pop("R3 drain", 48'h5000_0000_0000 + W'(i * 16'h0101));
         if (i == 18) chk_b("R5 flag cleared by next command", overflow, 1'b0);
      end
      chk_b("R3 empty after drain", tos_valid, 1'b0);
      do_op(C_POP, '0);
      chk_b("R5 pop on empty", underflow, 1'b1);
      chk_b("R5 no strobe on refused pop", got_wv, 1'b0);
   endtask

   task automatic t_underflow;
      do_op(C_PUSH, 48'h0000_1111_2222);
      do_op(C_ADD, '0);
      chk_b("R5 add with one cell", underflow, 1'b1);
      chk_w("R5 top unchanged", tos_data, 48'h0000_1111_2222);
      do_op(C_PUSH, 48'h0000_3333_4444);
      do_op(C_SWAP, '0);
      chk_b("R5 swap with two cells ok", underflow, 1'b0);
      do_op(C_PUSH, 48'h0000_5555_6666);
      do_op(C_ADD2, '0);
      chk_b("R5 double add with three cells", underflow, 1'b1);
      chk_w("R5 top unchanged after double add", tos_data, 48'h0000_5555_6666);
      expect_pop("R5 depth kept a", 48'h0000_5555_6666);
      chk_b("R5 flag cleared", underflow, 1'b0);
      expect_pop("R5 depth kept b", 48'h0000_1111_2222);
      expect_pop("R5 depth kept c", 48'h0000_3333_4444);
      chk_b("R5 empty", tos_valid, 1'b0);
   endtask

   task automatic t_add;
      do_op(C_PUSH, 48'h0000_0000_00AB);
      do_op(C_PUSH, 48'hFFFF_FFFF_FFF0);
      do_op(C_PUSH, 48'h0000_0000_0020);
      do_op(C_ADD, '0);
      chk_w("R6 wrapped sum", tos_data, 48'h0000_0000_0010);
      chk_b("R6 no underflow", underflow, 1'b0);
      expect_pop("R6 sum popped", 48'h0000_0000_0010);
      expect_pop("R6 stack moved up", 48'h0000_0000_00AB);
   endtask

   task automatic t_add2;
      logic [W-1:0] a_hi, a_lo, b_hi, b_lo, c;
      logic [2*W-1:0] s;
      a_hi = 48'h0000_0001_0000; a_lo = 48'hFFFF_FFFF_FFFF;
      b_hi = 48'h1234_0000_0001; b_lo = 48'h0000_0000_0001;
      c    = 48'h0C0C_0C0C_0C0C;
      s    = {a_hi, a_lo} + {b_hi, b_lo};
      do_op(C_PUSH, c);
      do_op(C_PUSH, b_lo);
      do_op(C_PUSH, b_hi);
      do_op(C_PUSH, a_lo);
      do_op(C_PUSH, a_hi);
      do_op(C_ADD2, '0);
      chk_b("R7 accepted", underflow, 1'b0);
      expect_pop("R7 high half", s[2*W-1:W]);
      expect_pop("R7 low half", s[W-1:0]);
      expect_pop("R7 moved up two", c);
      chk_b("R7 empty", tos_valid, 1'b0);
   endtask

   task automatic t_swap_dup;
      do_op(C_PUSH, 48'h0000_0000_0AAA);
      do_op(C_PUSH, 48'h0000_0000_0BBB);
      do_op(C_SWAP, '0);
      chk_w("R8 swapped top", tos_data, 48'h0000_0000_0AAA);
      expect_pop("R8 first", 48'h0000_0000_0AAA);
      expect_pop("R8 second", 48'h0000_0000_0BBB);
      do_op(C_PUSH, 48'h7777_0000_7777);
      do_op(C_DUP, '0);
      expect_pop("R9 copy", 48'h7777_0000_7777);
      expect_pop("R9 original", 48'h7777_0000_7777);
      chk_b("R9 empty", tos_valid, 1'b0);
   endtask

   task automatic t_zero_erase;
      do_op(C_PUSH, 48'h0000_9999_0000);
      do_op(C_ZERO, 48'hFFFF_FFFF_FFFF);
      chk_b("R10 zero is valid", tos_valid, 1'b1);
      chk_w("R10 zero data", tos_data, '0);
      do_op(C_ERASE, '0);
      chk_b("R11 erase no strobe", got_wv, 1'b0);
      chk_w("R11 stack moved up", tos_data, 48'h0000_9999_0000);
      do_op(C_ERASE, '0);
      chk_b("R11 erase to empty", tos_valid, 1'b0);
      do_op(C_ERASE, '0);
      chk_b("R5 erase on empty", underflow, 1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_push_timing();
      t_fill();
      t_underflow();
      t_add();
      t_add2();
      t_swap_dup();
      t_zero_erase();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule